// File: doc/BRIEF.md
# Grouped Interrupt Controller with Completion Coalescing

This block gathers ten interrupt-capable status events of an Ethernet MAC into a sticky status register. Each bit can be masked on its own through an enable register. The enabled bits form two group summaries: one for normal conditions and one for abnormal conditions. Together the two summaries drive a single interrupt line towards the host.

Transmit completion and receive completion do not set their status bits directly. Each passes through its own coalescing unit, which holds a 4-bit frame counter and a 4-bit timer. The unit raises the status bit when the programmed number of completions has been seen, or when the programmed time has passed since the first completion of a batch, whichever comes first. Software clears status bits by writing ones to them. It programs the enable and coalescing registers through a simple single-cycle register port.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the status, enable and coalescing registers read 0 and `irq` is low.
- R2: A high `src_ev[i]` at a clock edge sets status bit i at that edge, for i in 1, 3..9. The bit stays set until it is cleared. Bits 0 (transmit completion) and 2 (receive completion) are set only by their coalescing units.
- R3: A write to address 0 clears every status bit whose write-data bit in [9:0] is 1. A set arriving at the same edge wins over the clear.
- R4: A status bit that is set but not enabled (enable register bit i at address 1, bits [9:0]) still reads as set and does not raise `irq`.
- R5: Status bits 0..4 form the normal group and bits 5..9 form the abnormal group. The normal summary reads at bit 10 of address 0 and the abnormal summary at bit 11. Each summary is 1 while any enabled bit of its group is set. `irq` is the OR of the two summaries.
- R6: Address 2 holds the coalescing settings: [3:0] transmit frame threshold, [7:4] transmit timer, [11:8] receive frame threshold, [15:12] receive timer. Unused bits read 0, and address 3 reads 0.
- R7: When a unit's threshold and timer are both 0, each completion sets its status bit at the same edge.
- R8: With threshold N > 0, the Nth completion of a batch sets the status bit at its own edge, and no earlier completion of the batch does.
- R9: With timer T > 0, the status bit is set T*TICK_DIV clock cycles after the edge of the batch's first completion, unless the threshold fired first.
- R10: After a unit fires it starts a new batch from zero. The transmit and receive units run independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 coalescing) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| src_ev | input | 10 | One-cycle event pulses per status source; bits 0 and 2 are completions |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a coalescing unit that is part-way through a batch, with the counter short of its threshold and the timer running. The stimulus programs a threshold above the number of completions it sends, then counts clock cycles exactly after the first completion. It checks the status bit one cycle before the expected timer edge and again on that edge. A second batch after the clear confirms that the counter restarted from zero. A separate case lines up an event pulse and a write-one-clear on the same edge to exercise the set-over-clear priority.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;

    localparam int NUM_SRC  = 10;
    localparam int MIT_W    = 4;
    localparam int NUM_DIR  = 2;
    localparam int TX_BIT   = 0;
    localparam int RX_BIT   = 2;
    localparam int NSUM_POS = NUM_SRC;
    localparam int ASUM_POS = NUM_SRC + 1;

    localparam logic [NUM_SRC-1:0] NORMAL_MASK = 10'b00000_11111;

    typedef enum logic [1:0] {
        A_STAT = 2'd0,
        A_ENAB = 2'd1,
        A_MITG = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [MIT_W-1:0] timer;
        logic [MIT_W-1:0] frames;
    } mit_cfg_t;

    function automatic int done_bit(input int dir);
        return (dir == 0) ? TX_BIT : RX_BIT;
    endfunction

    function automatic logic [NUM_SRC-1:0] group_mask(input int grp);
        return (grp == 0) ? NORMAL_MASK : ~NORMAL_MASK;
    endfunction

endpackage

// File: rtl/irq_mitig_unit.sv
module irq_mitig_unit
    import irq_coalesce_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  mit_cfg_t cfg,
    output logic     fire
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [MIT_W-1:0] CNT_MAX  = '1;

    logic             pending;
    logic [MIT_W-1:0] cnt;
    logic [MIT_W-1:0] units;
    logic [PRE_W-1:0] pre;

    logic bypass, cnt_hit, tick_end, tmr_hit;

    always_comb begin
        bypass   = (cfg.frames == '0) && (cfg.timer == '0);
        cnt_hit  = done && (cfg.frames != '0) &&
                   (({1'b0, cnt} + 1'b1) >= {1'b0, cfg.frames});
        tick_end = (pre == PRE_LAST);
        tmr_hit  = pending && (cfg.timer != '0) && tick_end &&
                   (units == MIT_W'(cfg.timer - 1'b1));
        fire     = bypass ? done : (cnt_hit || tmr_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || fire || bypass) begin
            pending <= 1'b0;
            cnt     <= '0;
            units   <= '0;
            pre     <= '0;
        end else if (pending) begin
            pre   <= tick_end ? '0 : pre + 1'b1;
            units <= tick_end ? units + 1'b1 : units;
            if (done && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end else if (done) begin
            pending <= 1'b1;
            cnt     <= MIT_W'(1);
            units   <= '0;
            pre     <= '0;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_coalesce_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_wdata,
    output logic [NUM_SRC-1:0] stat,
    output logic [NUM_SRC-1:0] en,
    output logic [1:0]         summary
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_vec) | set_vec;
            if (en_wr)
                en <= en_wdata;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        assign summary[g] = |(stat & en & group_mask(g));
    end

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
    import irq_coalesce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] en,
    input  logic [1:0]         summary,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic               en_wr,
    output logic [NUM_SRC-1:0] en_wdata,
    output mit_cfg_t           mit_cfg [NUM_DIR]
);
    localparam int CFG_W = NUM_DIR * 2 * MIT_W;

    reg_addr_e        addr;
    logic [CFG_W-1:0] cfg_q;

    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (reg_wr && addr == A_MITG)
            cfg_q <= reg_wdata[CFG_W-1:0];
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_cfg
        assign mit_cfg[d] = cfg_q[d*2*MIT_W +: 2*MIT_W];
    end

    always_comb begin
        clr_vec  = (reg_wr && addr == A_STAT) ? reg_wdata[NUM_SRC-1:0] : '0;
        en_wr    = reg_wr && (addr == A_ENAB);
        en_wdata = reg_wdata[NUM_SRC-1:0];
        case (addr)
            A_STAT:  reg_rdata = DATA_W'({summary[1], summary[0], stat});
            A_ENAB:  reg_rdata = DATA_W'(en);
            A_MITG:  reg_rdata = DATA_W'(cfg_q);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coalesce_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_ev,
    output logic               irq
);
    logic [NUM_SRC-1:0] stat_q, en_q, set_vec, clr_vec, en_wdata;
    logic [1:0]         summary;
    logic               en_wr;
    logic [NUM_DIR-1:0] dir_fire;
    mit_cfg_t           mit_cfg [NUM_DIR];

    irq_reg_if #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stat      (stat_q),
        .en        (en_q),
        .summary   (summary),
        .clr_vec   (clr_vec),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .mit_cfg   (mit_cfg)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_mit
        irq_mitig_unit #(.TICK_DIV(TICK_DIV)) u_mit (
            .clk  (clk),
            .rst  (rst),
            .done (src_ev[done_bit(d)]),
            .cfg  (mit_cfg[d]),
            .fire (dir_fire[d])
        );
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_set
        if (i == TX_BIT) begin : g_tx
            assign set_vec[i] = dir_fire[0];
        end else if (i == RX_BIT) begin : g_rx
            assign set_vec[i] = dir_fire[1];
        end else begin : g_raw
            assign set_vec[i] = src_ev[i];
        end
    end

    irq_status_bank u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .stat     (stat_q),
        .en       (en_q),
        .summary  (summary)
    );

    assign irq = summary[0] | summary[1];

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk
    import irq_coalesce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] set_vec
);
    // R2: a set source is held on the following cycle
    p_set_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));

    // R2: with no write, status only gains bits
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> (stat == ($past(stat) | $past(set_vec))));

    // R3: write-one-clear removes unset bits
    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=>
        ((stat & $past(reg_wdata[NUM_SRC-1:0] & ~set_vec)) == '0));

    // R4: nothing enabled and set means no interrupt
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((stat & en) == '0) |-> !irq);

    // R5: any enabled set bit raises the interrupt
    p_irq_raised_r5: assert property (@(posedge clk) disable iff (rst)
        ((stat & en) != '0) |-> irq);

endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .stat      (stat_q),
    .en        (en_q),
    .set_vec   (set_vec)
);

// File: tb/tb_irq_coalesce_ctrl.sv
module tb_irq_coalesce_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [9:0]  src_ev;
    logic        irq;

    int checks = 0;
    int errors = 0;

    irq_coalesce_ctrl #(.DATA_W(32), .TICK_DIV(TICK_DIV)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_ev(src_ev), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        src_ev = v;
        @(negedge clk);
        src_ev = '0;
    endtask

    task automatic clear_all;
        wr(2'd0, 32'h3FF);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check(d == 0, "R1 status", d, 0);
        rd(2'd1, d); check(d == 0, "R1 enable", d, 0);
        rd(2'd2, d); check(d == 0, "R1 coalesce", d, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(2'd2, 32'hFFFF_4321);
        rd(2'd2, d); check(d == 32'h0000_4321, "R6 coalesce fields", d, 32'h4321);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); check(d == 0, "R6 addr3 reads zero", d, 0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check(d == 32'h3FF, "R6 enable width", d, 32'h3FF);
        wr(2'd1, 0);
        wr(2'd2, 0);
    endtask

    task automatic t_sticky_w1c;
        logic [31:0] d;
        pulse(10'b10_0000_1010);
        repeat (3) @(negedge clk);
        rd(2'd0, d); check(d[9:0] == 10'h20A, "R2 sticky set", d, 32'h20A);
        wr(2'd0, 32'h008);
        rd(2'd0, d); check(d[9:0] == 10'h202, "R3 partial clear", d, 32'h202);
        // same-edge set and clear of bit 5
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h020; src_ev = 10'h020;
        @(negedge clk);
        reg_wr = 1'b0; src_ev = '0;
        rd(2'd0, d); check(d[5] == 1'b1, "R3 set wins over clear", d, 32'h222);
        clear_all;
        rd(2'd0, d); check(d == 0, "R3 all cleared", d, 0);
    endtask

    task automatic t_mask_groups;
        logic [31:0] d;
        pulse(10'h008);
        rd(2'd0, d);
        check(d[3] == 1'b1 && irq == 1'b0, "R4 masked bit set, no irq", {irq, d[30:0]}, 32'h8);
        wr(2'd1, 32'h008);
        rd(2'd0, d);
        check(d[10] == 1'b1 && d[11] == 1'b0 && irq, "R5 normal summary", d, 32'h408);
        wr(2'd1, 32'h080);
        pulse(10'h080);
        rd(2'd0, d);
        check(d[11:10] == 2'b10 && irq, "R5 abnormal summary only", d, 32'h888);
        pulse(10'h040);
        wr(2'd1, 32'h0C0);
        wr(2'd0, 32'h080);
        rd(2'd0, d);
        check(d[11] == 1'b1 && irq, "R5 summary held by other bit", d, 32'h848);
        clear_all;
        rd(2'd0, d);
        check(d == 0 && !irq, "R5 summary drops", d, 0);
        wr(2'd1, 0);
    endtask

    task automatic t_bypass;
        logic [31:0] d;
        pulse(10'h001);
        rd(2'd0, d); check(d[0] == 1'b1, "R7 tx bypass", d, 1);
        pulse(10'h004);
        rd(2'd0, d); check(d[2] == 1'b1, "R7 rx bypass", d, 5);
        clear_all;
    endtask

    task automatic t_frames;
        logic [31:0] d;
        wr(2'd2, 32'hF300);          // rx: threshold 3, timer 15
        pulse(10'h004); pulse(10'h004);
        rd(2'd0, d); check(d[2] == 1'b0, "R8 below threshold", d, 0);
        pulse(10'h004);
        rd(2'd0, d); check(d[2] == 1'b1, "R8 threshold reached", d, 4);
        clear_all;
        pulse(10'h004); pulse(10'h004);
        rd(2'd0, d); check(d[2] == 1'b0, "R10 batch restarted", d, 0);
        pulse(10'h004);
        rd(2'd0, d); check(d[2] == 1'b1, "R10 second batch fires", d, 4);
        clear_all;
        wr(2'd2, 0);
    endtask

    task automatic t_timer;
        logic [31:0] d;
        wr(2'd2, 32'h0000_0034);     // tx: threshold 4, timer 3
        pulse(10'h001);
        repeat (3*TICK_DIV - 1) @(negedge clk);
        rd(2'd0, d); check(d[0] == 1'b0, "R9 timer one cycle early", d, 0);
        @(negedge clk);
        rd(2'd0, d); check(d[0] == 1'b1, "R9 timer expiry", d, 1);
        check(d[2] == 1'b0, "R10 rx unaffected by tx", d, 1);
        clear_all;
        // rx threshold 1 while tx batch is pending
        wr(2'd2, 32'h0000_0134);
        pulse(10'h001);
        pulse(10'h004);
        rd(2'd0, d);
        check(d[2:0] == 3'b100, "R10 rx fires independently", d, 4);
        clear_all;
        wr(2'd2, 0);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_ev = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regmap;
        t_sticky_w1c;
        t_mask_groups;
        t_bypass;
        t_frames;
        t_timer;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule